// File: doc/BRIEF.md
# Folded Single-Row Systolic Array Controller

This block sequences and feeds a single physical row of systolic cells so that the row can stand in for every layer of a trapezoidal Schur complement array. For an N x N problem the row holds one boundary cell (column 0) and 2N-1 internal cells (columns 1 to 2N-1), 2N columns in all. The block generates three one-bit control signals for each column: the cell mode, the clear of the cell's internal register, and the input select. It also contains the register columns that carry each internal cell's output back to the input of its left-hand neighbour. The cells and the skew packer and unpacker sit outside the block and connect only through its ports.

One run takes 2(N*N-1) cycles. The run splits into N+1 passes of D = 2(N-1) cycles each. In the first pass the row takes fresh matrix data. In each of the N later passes it takes the recirculated results of the pass before. The control signals are formed for column 0 and then reach each further column one clock later than the column to its left, which follows the skew of the data stream. Runs repeat back to back until reset, and a reset restarts the sequence from its first cycle.

Top module: `fold_row_ctrl`

## Requirements
- R1: In the first cycle after reset, column 0 shows sel=1, mode=1 and clear=1. Every other column shows 0 on all three controls, and done is 0.
- R2: The sequence repeats with a period of T = 2(N*N-1) cycles. Each run is made of N+1 passes of D = 2(N-1) cycles.
- R3: The select of column 0 is 1 in every cycle of the first pass of a run and 0 in every later pass. Select value 1 means matrix data and 0 means feedback data.
- R4: The mode of column 0 is 1 (triangulation) in slots 0 to N-2 of every pass and 0 (annulment) in slots N-1 to D-1.
- R5: The clear of column 0 is 1 only in slot 0 of each pass.
- R6: For column c > 0, each control equals the column-0 control of c cycles earlier, and it is 0 while fewer than c cycles have passed since reset.
- R7: When a column's select is 1, that column's cell input equals its matrix input in the same cycle.
- R8: When a column's select is 0, the cell input of column c < 2N-1 equals the output of cell c+1 from D cycles earlier, or 0 if fewer than D cycles have passed since reset. The cell input of column 2N-1 is 0.
- R9: done is 1 for exactly one cycle, in the first cycle that follows each complete run (cycle index k*T with k >= 1 since reset). It is 0 at all other times.
- R10: A reset asserted in the middle of a run returns all counters and control delays to their initial state. The sequence then restarts as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mat_in | input | 2N*W | Skewed matrix stream, one W-bit word per column (column c at bits c*W upward) |
| cell_out | input | 2N*W | Output word of each cell, same packing |
| cell_in | output | 2N*W | Selected input word for each cell |
| cell_mode | output | 2N | Per-column mode, 1 = triangulation, 0 = annulment |
| cell_clear | output | 2N | Per-column clear of the cell's internal register |
| cell_sel | output | 2N | Per-column input select, 1 = matrix, 0 = feedback |
| done | output | 1 | One-cycle pulse after each complete run |

## Verification
The done pulse of one run falls in the same cycle as column 0 starting the next run. In that cycle column 0 raises select, mode and clear together, while the columns further right are still playing out the tail of the previous run's last pass. The bench provokes this overlap by running several complete runs back to back, and it restarts the sequence with a reset in the middle of a run. A behavioural model computes every column's controls and every cell input from the cycle count alone, and every cycle is compared against it. This includes the cycles where a column's select falls and the recirculated words arrive in the same cycle.

// File: rtl/fold_pkg.sv
package fold_pkg;

   // Depth of each recirculation column for an N x N problem
   function automatic int unsigned bank_depth(input int unsigned n);
      return 2 * (n - 1);
   endfunction

   // Cycles in one complete run
   function automatic int unsigned run_cycles(input int unsigned n);
      return 2 * (n * n - 1);
   endfunction

   // Control bundle for one column
   typedef struct packed {
      logic sel;
      logic mode;
      logic clear;
   } fold_ctl_t;

endpackage

// File: rtl/fold_seq.sv
module fold_seq
   import fold_pkg::*;
#(
   parameter int unsigned N = 3
) (
   input  logic      clk,
   input  logic      rst_n,
   output fold_ctl_t head_o,
   output logic      done_o
);
   localparam int unsigned D  = bank_depth(N);
   localparam int unsigned T  = run_cycles(N);
   localparam int unsigned SW = (D > 1) ? $clog2(D) : 1;
   localparam int unsigned PW = $clog2(N + 1);
   localparam int unsigned CW = $clog2(T);

   logic [SW-1:0] slot_q;
   logic [PW-1:0] pass_q;
   logic [CW-1:0] cyc_q;
   logic          done_q;
   logic          slot_end, pass_end, run_end;

   assign slot_end = (slot_q == SW'(D - 1));
   assign pass_end = (pass_q == PW'(N));
   assign run_end  = (cyc_q == CW'(T - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_q <= '0;
         pass_q <= '0;
         cyc_q  <= '0;
         done_q <= 1'b0;
      end else begin
         cyc_q  <= run_end ? '0 : cyc_q + 1'b1;
         slot_q <= slot_end ? '0 : slot_q + 1'b1;
         if (slot_end)
            pass_q <= pass_end ? '0 : pass_q + 1'b1;
         done_q <= run_end;
      end
   end

   always_comb begin
      head_o.sel   = (pass_q == '0);
      head_o.mode  = (slot_q < SW'(N - 1));
      head_o.clear = (slot_q == '0);
   end

   assign done_o = done_q;

   AST_RUN_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_q == '0) |-> (slot_q == '0 && pass_q == '0)); // R2
   AST_SEL_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(head_o.sel) |-> (slot_q == '0 && pass_q == PW'(1))); // R3
   AST_MODE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(head_o.mode) |-> (slot_q == SW'(N - 1))); // R4
   AST_CLEAR_IN_TRI: assert property (@(posedge clk) disable iff (!rst_n)
      head_o.clear |-> head_o.mode); // R5
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R9
   AST_DONE_AT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (head_o.sel && head_o.clear)); // R9

endmodule

// File: rtl/fold_skew.sv
module fold_skew
   import fold_pkg::*;
#(
   parameter int unsigned NCOL = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  fold_ctl_t       head_i,
   output logic [NCOL-1:0] mode_o,
   output logic [NCOL-1:0] clear_o,
   output logic [NCOL-1:0] sel_o
);
   fold_ctl_t tap [NCOL];
   logic      warm_q;

   always_ff @(posedge clk) begin
      if (!rst_n) warm_q <= 1'b0;
      else        warm_q <= 1'b1;
   end

   for (genvar c = 0; c < NCOL; c++) begin : g_col
      if (c == 0) begin : g_head
         assign tap[c] = head_i;
      end else begin : g_dly
         fold_ctl_t q;
         always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= tap[c-1];
         end
         assign tap[c] = q;

         AST_SKEW_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
            warm_q |-> (tap[c] == $past(tap[c-1]))); // R6
      end
      assign mode_o[c]  = tap[c].mode;
      assign clear_o[c] = tap[c].clear;
      assign sel_o[c]   = tap[c].sel;
   end

endmodule

// File: rtl/fold_bank.sv
module fold_bank #(
   parameter int unsigned W = 16,
   parameter int unsigned D = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] tail
);
   logic [W-1:0] st [D];

   for (genvar j = 0; j < D; j++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n)      st[j] <= '0;
         else if (j == 0) st[j] <= din;
         else             st[j] <= st[(j == 0) ? 0 : j-1];
      end
   end

   assign tail = st[D-1];

endmodule

// File: rtl/fold_row_ctrl.sv
module fold_row_ctrl
   import fold_pkg::*;
#(
   parameter int unsigned N = 3,
   parameter int unsigned W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2*N*W-1:0]  mat_in,
   input  logic [2*N*W-1:0]  cell_out,
   output logic [2*N*W-1:0]  cell_in,
   output logic [2*N-1:0]    cell_mode,
   output logic [2*N-1:0]    cell_clear,
   output logic [2*N-1:0]    cell_sel,
   output logic              done
);
   localparam int unsigned NCOL = 2 * N;
   localparam int unsigned D    = bank_depth(N);

   if (N < 2 || N > 6) begin : g_bad_n
      $error("fold_row_ctrl: N must lie in 2..6");
   end
   if (W < 2) begin : g_bad_w
      $error("fold_row_ctrl: W must be at least 2");
   end

   fold_ctl_t head;
   logic [W-1:0] fb [NCOL];

   fold_seq #(.N(N)) seq_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .head_o (head),
      .done_o (done)
   );

   fold_skew #(.NCOL(NCOL)) skew_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .head_i  (head),
      .mode_o  (cell_mode),
      .clear_o (cell_clear),
      .sel_o   (cell_sel)
   );

   for (genvar c = 0; c < NCOL; c++) begin : g_col
      if (c < NCOL - 1) begin : g_fb
         fold_bank #(.W(W), .D(D)) bank_i (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (cell_out[(c+1)*W +: W]),
            .tail  (fb[c])
         );
      end else begin : g_edge
         assign fb[c] = '0;
      end
      assign cell_in[c*W +: W] = cell_sel[c] ? mat_in[c*W +: W] : fb[c];
   end

   AST_EDGE_NO_FEEDBACK: assert property (@(posedge clk) disable iff (!rst_n)
      !cell_sel[NCOL-1] |-> (cell_in[(NCOL-1)*W +: W] == '0)); // R8
   AST_DONE_ONLY_COL0_START: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> cell_clear[0]); // R9

endmodule

// File: tb/fold_row_ctrl_tb_top.sv
`timescale 1ns/1ps
module fold_row_ctrl_tb_top;
   localparam int N    = 3;
   localparam int W    = 16;
   localparam int NCOL = 2 * N;
   localparam int D    = 2 * (N - 1);
   localparam int T    = 2 * (N * N - 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NCOL*W-1:0] mat_in = '0, cell_out = '0, cell_in;
   logic [NCOL-1:0]   cell_mode, cell_clear, cell_sel;
   logic              done;

   int errors = 0, checks = 0, t = 0;
   bit finished = 0;
   logic [NCOL*W-1:0] hist [$];

   always #2 clk = ~clk;

   fold_row_ctrl #(.N(N), .W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .mat_in(mat_in), .cell_out(cell_out),
      .cell_in(cell_in), .cell_mode(cell_mode), .cell_clear(cell_clear),
      .cell_sel(cell_sel), .done(done)
   );

   task automatic chk(input string tag, input int col, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s t=%0d col=%0d actual=%0h expected=%0h", tag, t, col, act, exp);
      end
   endtask

   // reference: {sel, mode, clear} of column 0 at cycle u since reset
   function automatic logic [2:0] ref_ctl(input int u);
      int v, k, s;
      if (u < 0) return 3'b000;
      v = u % T; k = v / D; s = v % D;
      return {k == 0, s < N - 1, s == 0};
   endfunction

   task automatic step();
      logic [2:0] e;
      logic [W-1:0] exp_in;
      for (int c = 0; c < NCOL; c++) begin
         mat_in[c*W +: W]   = W'($urandom);
         cell_out[c*W +: W] = W'($urandom);
      end
      #0.5;
      for (int c = 0; c < NCOL; c++) begin
         e = ref_ctl(t - c);
         if (c == 0) begin
            chk("R3 sel col0", c, cell_sel[c], e[2]);
            chk("R4 mode col0", c, cell_mode[c], e[1]);
            chk("R5 clear col0", c, cell_clear[c], e[0]);
         end else begin
            chk("R6 skewed sel", c, cell_sel[c], e[2]);
            chk("R6 skewed mode", c, cell_mode[c], e[1]);
            chk("R6 skewed clear", c, cell_clear[c], e[0]);
         end
         if (e[2]) begin
            exp_in = mat_in[c*W +: W];
            chk("R7 matrix input", c, cell_in[c*W +: W], exp_in);
         end else begin
            if (c == NCOL - 1 || t < D) exp_in = '0;
            else exp_in = hist[t - D][(c+1)*W +: W];
            chk("R8 feedback input", c, cell_in[c*W +: W], exp_in);
         end
      end
      chk("R9 done pulse", 0, done, (t > 0 && t % T == 0));
      if (t > 0 && t % T == 0) chk("R2 run period", 0, cell_sel[0] & cell_clear[0], 1);
      hist.push_back(cell_out);
      t++;
   endtask

   task automatic start_after_reset(input string tag);
      @(negedge clk);
      rst_n = 1'b1;
      t = 0;
      hist.delete();
      #0.1;
      chk(tag, 0, {cell_sel[0], cell_mode[0], cell_clear[0]}, 3'b111);
      chk(tag, 1, {cell_sel[NCOL-1:1], cell_mode[NCOL-1:1], cell_clear[NCOL-1:1]}, 0);
      chk(tag, 0, done, 0);
      #0.4;
      step();
   endtask

   initial begin
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      start_after_reset("R1 reset state");
      repeat (3 * T + 3) begin @(negedge clk); step(); end
      // reset in the middle of a run
      repeat (7) begin @(negedge clk); step(); end
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      start_after_reset("R10 restart");
      repeat (2 * T + 2) begin @(negedge clk); step(); end
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule